// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block gives a host a way to configure a set of logical devices through only two byte-wide I/O locations: an index port and a data port. Configuration space is locked after reset. The host unlocks it by writing the open key to the index port twice in a row. It locks it again with the close key. While the space is open, a byte written to the index port picks a register, and the data port then reads or writes that register.

A global select register chooses which logical device's bank the data port reaches. Each bank holds an enable bit, a 16-bit I/O base split into high and low bytes, and an IRQ number. These values drive the block's outputs so that the device logic outside can use them. Two read-only identifier registers return a major and a minor chip code. The major code is never 0xFF, so a host that reads 0xFF there knows that nothing answers at that port pair.

Host accesses arrive on a valid/ready request channel. The block never applies back-pressure, so `req_ready` is held high and every request is taken in the cycle it is presented. A read answers one cycle later with a single-cycle `rd_valid` pulse. The response has no ready signal, so the host must take it in that cycle.

Top module: `cfgp_top`

## Requirements
- R1: After reset the space is locked, `cfg_mode` is 0, the select register and the index register are 0x00, and every bank's enable, base and IRQ are 0.
- R2: Two accepted index-port writes of OPEN_KEY (default 0x87) with no other access between them open the space, and `cfg_mode` is 1 in the cycle after the second write is accepted.
- R3: Any of the following between the two key writes restarts the sequence, so one further key write does not open the space: an index-port write of any other value, or any data-port access.
- R4: While the space is open, an index-port write of CLOSE_KEY (default 0xAA) locks it and leaves the index register unchanged. Any other index-port write while open loads the index register, including OPEN_KEY.
- R5: While the space is locked, reads of either port return 0xFF and data-port writes change no register and no output.
- R6: While the space is open, a read of the index port returns the current index, and a data-port access reaches the register that the index names.
- R7: Index 0x07 is the device select register. It can be read and written, and it decides which bank the bank indexes reach.
- R8: Index 0x30 is the bank enable. Only bit 0 of a write is stored: 0x01 enables the device and 0x00 disables it. A read returns 0x00 or 0x01, and the stored bit drives `dev_enable[n]` for the selected device n.
- R9: Index 0x60 is the base high byte, 0x61 the base low byte and 0x70 the IRQ number, per bank. `dev_base[16n+15:16n]` is {high, low} and `dev_irq[8n+7:8n]` is the IRQ number of device n.
- R10: Index 0x20 reads ID_MAJOR (default 0xC5) and 0x21 reads ID_MINOR (default 0x62). Writes to them are ignored.
- R11: With a select value of NUM_DEV or more, or with an index that names no register, data reads return 0xFF and data writes are ignored.
- R12: `req_ready` is always 1. A request is accepted in every cycle with `req_valid` high. An accepted read gives `rd_valid` high with `rd_data` in the next cycle. `rd_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted (held at 1) |
| req_port | input | 1 | 0 selects the index port, 1 selects the data port |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response valid, one cycle after the read |
| rd_data | output | 8 | Read response byte |
| cfg_mode | output | 1 | Configuration space open |
| dev_enable | output | NUM_DEV | Per-device enable bit |
| dev_base | output | 16*NUM_DEV | Per-device I/O base, device n at bits 16n+15:16n |
| dev_irq | output | 8*NUM_DEV | Per-device IRQ number, device n at bits 8n+7:8n |

## Verification
The hardest case to reach is a broken unlock sequence: a single key write followed by an interrupting access and then one more key write. That case must leave the space locked, and random traffic seldom produces it. Directed cases therefore insert a foreign index byte and a data-port read between key writes, and then check `cfg_mode` and a locked read. Random traffic then mixes key pairs, the close key, select values above the device count and unmapped indexes. It compares every read and every bank output with a bench model of the register space.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  localparam logic [7:0] IDX_SELECT  = 8'h07;
  localparam logic [7:0] IDX_ID_MAJ  = 8'h20;
  localparam logic [7:0] IDX_ID_MIN  = 8'h21;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] RD_FLOAT    = 8'hFF;
endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
  import cfgp_pkg::*;
#(
  parameter logic [7:0] OPEN_KEY  = 8'h87,
  parameter logic [7:0] CLOSE_KEY = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_acc,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       idx_load
);
  lock_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LK_CLOSED;
    end else begin
      case (state_q)
        LK_CLOSED: if (idx_wr) state_q <= (wdata == OPEN_KEY) ? LK_HALF : LK_CLOSED;
        LK_HALF: begin
          if (idx_wr)        state_q <= (wdata == OPEN_KEY) ? LK_OPEN : LK_CLOSED;
          else if (data_acc) state_q <= LK_CLOSED;
        end
        LK_OPEN:   if (idx_wr && wdata == CLOSE_KEY) state_q <= LK_CLOSED;
        default:   state_q <= LK_CLOSED;
      endcase
    end
  end

  assign open_o   = (state_q == LK_OPEN);
  assign idx_load = idx_wr && open_o && (wdata != CLOSE_KEY);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        enable_o,
  output logic [15:0] base_o,
  output logic [7:0]  irq_o,
  output logic [7:0]  rd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      base_o   <= '0;
      irq_o    <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_ENABLE:  enable_o     <= wdata[0];
        IDX_BASE_HI: base_o[15:8] <= wdata;
        IDX_BASE_LO: base_o[7:0]  <= wdata;
        IDX_IRQ:     irq_o        <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_ENABLE:  rd_o = {7'b0, enable_o};
      IDX_BASE_HI: rd_o = base_o[15:8];
      IDX_BASE_LO: rd_o = base_o[7:0];
      IDX_IRQ:     rd_o = irq_o;
      default:     rd_o = RD_FLOAT;
    endcase
  end
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
  import cfgp_pkg::*;
#(
  parameter int         NUM_DEV   = 4,
  parameter logic [7:0] OPEN_KEY  = 8'h87,
  parameter logic [7:0] CLOSE_KEY = 8'hAA,
  parameter logic [7:0] ID_MAJOR  = 8'hC5,
  parameter logic [7:0] ID_MINOR  = 8'h62
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_port,
  input  logic                    req_write,
  input  logic [7:0]              req_wdata,
  output logic                    rd_valid,
  output logic [7:0]              rd_data,
  output logic                    cfg_mode,
  output logic [NUM_DEV-1:0]      dev_enable,
  output logic [16*NUM_DEV-1:0]   dev_base,
  output logic [8*NUM_DEV-1:0]    dev_irq
);
  localparam int BASE_W = 16;
  localparam int IRQ_W  = 8;

  logic       idx_wr, data_acc, data_wr, idx_load, open_w;
  logic [7:0] index_q, sel_q, bank_rd_sel, rd_next;
  logic [7:0] bank_rd [NUM_DEV];

  assign req_ready = 1'b1;
  assign idx_wr    = req_valid && req_write && !req_port;
  assign data_acc  = req_valid && req_port;
  assign data_wr   = data_acc && req_write && open_w;

  cfgp_unlock #(.OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_acc(data_acc),
    .wdata(req_wdata), .open_o(open_w), .idx_load(idx_load)
  );
  assign cfg_mode = open_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      sel_q   <= '0;
    end else begin
      if (idx_load) index_q <= req_wdata;
      if (data_wr && index_q == IDX_SELECT) sel_q <= req_wdata;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    cfgp_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr && sel_q == 8'(g)),
      .idx(index_q), .wdata(req_wdata),
      .enable_o(dev_enable[g]),
      .base_o(dev_base[BASE_W*g +: BASE_W]),
      .irq_o(dev_irq[IRQ_W*g +: IRQ_W]),
      .rd_o(bank_rd[g])
    );
  end

  always_comb begin
    bank_rd_sel = RD_FLOAT;
    for (int i = 0; i < NUM_DEV; i++)
      if (sel_q == 8'(i)) bank_rd_sel = bank_rd[i];
  end

  always_comb begin
    if (!open_w)        rd_next = RD_FLOAT;
    else if (!req_port) rd_next = index_q;
    else begin
      case (index_q)
        IDX_SELECT: rd_next = sel_q;
        IDX_ID_MAJ: rd_next = ID_MAJOR;
        IDX_ID_MIN: rd_next = ID_MINOR;
        default:    rd_next = bank_rd_sel;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= RD_FLOAT;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
  parameter int         NUM_DEV   = 4,
  parameter logic [7:0] OPEN_KEY  = 8'h87,
  parameter logic [7:0] CLOSE_KEY = 8'hAA
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_port,
  input logic                  req_write,
  input logic [7:0]            req_wdata,
  input logic                  rd_valid,
  input logic [7:0]            rd_data,
  input logic                  cfg_mode,
  input logic [NUM_DEV-1:0]    dev_enable,
  input logic [16*NUM_DEV-1:0] dev_base,
  input logic [8*NUM_DEV-1:0]  dev_irq
);
  // R2: space opens only right after an accepted open-key index write
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(req_valid && req_write && !req_port && req_wdata == OPEN_KEY));

  // R4: close key locks the space
  a_r4_close_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && req_valid && req_write && !req_port && req_wdata == CLOSE_KEY) |=> !cfg_mode);

  // R5: locked reads float high
  a_r5_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && req_valid && !req_write) |=> (rd_valid && rd_data == 8'hFF));

  // R5: nothing visible changes while locked
  a_r5_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(dev_enable) && $stable(dev_base) && $stable(dev_irq)));

  // R12: response timing and constant readiness
  a_r12_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  a_r12_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  a_r12_ready: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

bind cfgp_top cfgp_chk #(.NUM_DEV(NUM_DEV), .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .cfg_mode(cfg_mode),
  .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq)
);

// File: tb/tb_cfgp_top.sv
module tb_cfgp_top;
  localparam int N = 4;
  localparam logic [7:0] KO = 8'h87, KC = 8'hAA, MAJ = 8'hC5, MIN = 8'h62;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_port = 1'b0, req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, cfg_mode;
  logic [7:0] rd_data;
  logic [N-1:0] dev_enable;
  logic [16*N-1:0] dev_base;
  logic [8*N-1:0] dev_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  int ms = 0;
  logic [7:0] midx = 0, msel = 0;
  logic men [N];
  logic [7:0] mhi [N], mlo [N], mirq [N];

  always #4 clk = ~clk;

  cfgp_top #(.NUM_DEV(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cfg_mode(cfg_mode),
    .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input bit port);
    if (ms != 2) return 8'hFF;
    if (!port) return midx;
    case (midx)
      8'h07: return msel;
      8'h20: return MAJ;
      8'h21: return MIN;
      default: begin
        if (msel >= N) return 8'hFF;
        case (midx)
          8'h30: return {7'b0, men[msel[1:0]]};
          8'h60: return mhi[msel[1:0]];
          8'h61: return mlo[msel[1:0]];
          8'h70: return mirq[msel[1:0]];
          default: return 8'hFF;
        endcase
      end
    endcase
  endfunction

  task automatic model_apply(input bit port, input bit wr, input logic [7:0] d);
    if (!port && wr) begin
      case (ms)
        0: ms = (d == KO) ? 1 : 0;
        1: ms = (d == KO) ? 2 : 0;
        default: if (d == KC) ms = 0; else midx = d;
      endcase
    end else if (port) begin
      if (ms == 1) ms = 0;
      else if (ms == 2 && wr) begin
        if (midx == 8'h07) msel = d;
        else if (msel < N) begin
          case (midx)
            8'h30: men[msel[1:0]] = d[0];
            8'h60: mhi[msel[1:0]] = d;
            8'h61: mlo[msel[1:0]] = d;
            8'h70: mirq[msel[1:0]] = d;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic acc(input bit port, input bit wr, input logic [7:0] d, input string tag);
    logic [7:0] e;
    e = exp_read(port);
    @(negedge clk);
    req_valid = 1; req_port = port; req_write = wr; req_wdata = d;
    chk("R12 ready", {31'b0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R12 rd_valid", {31'b0, rd_valid}, {31'b0, !wr});
    if (!wr) chk(tag, {24'b0, rd_data}, {24'b0, e});
    model_apply(port, wr, d);
  endtask

  task automatic cmp_outputs(input string tag);
    for (int i = 0; i < N; i++) begin
      chk({tag, " R8 enable"}, {31'b0, dev_enable[i]}, {31'b0, men[i]});
      chk({tag, " R9 base"}, {16'b0, dev_base[16*i +: 16]}, {16'b0, mhi[i], mlo[i]});
      chk({tag, " R9 irq"}, {24'b0, dev_irq[8*i +: 8]}, {24'b0, mirq[i]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pick [10];
    pick = '{8'h87, 8'hAA, 8'h07, 8'h20, 8'h21, 8'h30, 8'h60, 8'h61, 8'h70, 8'h55};
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin men[i] = 0; mhi[i] = 0; mlo[i] = 0; mirq[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_mode", {31'b0, cfg_mode}, 0);
    chk("R1 enables", {28'b0, dev_enable}, 0);
    cmp_outputs("R1");
    acc(1, 0, 0, "R5 locked data read");
    acc(0, 0, 0, "R5 locked index read");
    // R3 broken sequences
    acc(0, 1, KO, "");
    acc(0, 1, 8'h07, "");
    acc(0, 1, KO, "");
    chk("R3 foreign byte breaks", {31'b0, cfg_mode}, 0);
    acc(0, 1, 8'h00, "");
    acc(0, 1, KO, "");
    acc(1, 0, 0, "R3 data read in half state");
    acc(0, 1, KO, "");
    chk("R3 data access breaks", {31'b0, cfg_mode}, 0);
    acc(0, 1, 8'h00, "");
    // R2 open
    acc(0, 1, KO, "");
    acc(0, 1, KO, "");
    chk("R2 open", {31'b0, cfg_mode}, 1);
    acc(0, 0, 0, "R1 R6 index after reset");
    acc(0, 1, 8'h07, "");
    acc(1, 0, 0, "R1 R7 select reset value");
    acc(1, 1, 8'h02, "");
    acc(1, 0, 0, "R7 select readback");
    acc(0, 1, 8'h30, "");
    acc(1, 1, 8'hFF, "");
    acc(1, 0, 0, "R8 enable bit0 only");
    chk("R8 dev_enable", {28'b0, dev_enable}, 32'h4);
    acc(0, 1, 8'h60, ""); acc(1, 1, 8'h12, "");
    acc(0, 1, 8'h61, ""); acc(1, 1, 8'h34, "");
    acc(0, 1, 8'h70, ""); acc(1, 1, 8'h05, "");
    chk("R9 base dev2", {16'b0, dev_base[47:32]}, 32'h1234);
    chk("R9 irq dev2", {24'b0, dev_irq[23:16]}, 32'h05);
    acc(0, 1, 8'h20, ""); acc(1, 0, 0, "R10 id major");
    acc(1, 1, 8'h00, ""); acc(1, 0, 0, "R10 id major after write");
    acc(0, 1, 8'h21, ""); acc(1, 0, 0, "R10 id minor");
    acc(0, 1, 8'h07, ""); acc(1, 1, 8'h09, "");
    acc(0, 1, 8'h60, ""); acc(1, 1, 8'h77, "");
    acc(1, 0, 0, "R11 out-of-range select");
    acc(0, 1, 8'h55, ""); acc(1, 0, 0, "R11 unmapped index");
    cmp_outputs("R11");
    acc(0, 1, KO, "");
    acc(0, 0, 0, "R4 open key loads index");
    acc(0, 1, 8'h70, "");
    acc(0, 1, KC, "");
    chk("R4 locked", {31'b0, cfg_mode}, 0);
    acc(1, 1, 8'h99, "");
    cmp_outputs("R5 locked write");
    acc(0, 1, KO, ""); acc(0, 1, KO, "");
    acc(0, 0, 0, "R4 index kept over lock");
    // random phase
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (ms != 2 && r < 2) begin
        acc(0, 1, KO, ""); acc(0, 1, KO, "");
      end else if (r < 5) begin
        acc(0, 1, ($urandom_range(0, 7) == 0) ? 8'($urandom) : pick[$urandom_range(0, 9)], "");
      end else if (r < 7) begin
        logic [7:0] d;
        d = (midx == 8'h07) ? 8'($urandom_range(0, 5)) : 8'($urandom);
        acc(1, 1, d, "");
      end else begin
        acc(r[0], 0, 0, "R6 random read");
      end
      chk("R2 R4 random mode", {31'b0, cfg_mode}, {31'b0, ms == 2});
    end
    cmp_outputs("R9 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule